// File: doc/BRIEF.md
# Programmable-Flag Threshold Offset Store

This block holds the two threshold offsets that a programmable-flag FIFO compares its fill level against. One offset sets the almost-empty point and the other the almost-full point. Each offset is kept as two byte-wide registers, a low byte and a high byte, so there are four registers in all. The registers are loaded from the FIFO's byte-wide data input on the write clock. They are read back onto the byte-wide data output on the read clock. Both happen only while the active-low load control is asserted.

The block reaches the four registers through pointers that advance on their own and wrap, so no register address is ever presented. The write domain keeps one pointer and the read domain keeps another. Both walk the registers in the fixed order almost-empty low, almost-empty high, almost-full low, almost-full high, and then start again. A load may stop after any number of bytes by releasing the load control. A later load picks up at the register after the last one written. The assembled offsets go straight to the flag comparators, which are outside this block, as `ADDR_W`-bit values.

Top module: `ofs_load_unit`

## Requirements
- R1: While `rst_n` is low, each clock edge restores the defaults. Both offsets become `EMPTY_DEF` and `FULL_DEF` (7 each). `dout` becomes zero. Both pointers return to the almost-empty low register.
- R2: On a rising `wr_clk` edge with `load_n` and `wen1_n` both low, `din` is stored into the register under the write pointer. The register order is index 0 almost-empty low, 1 almost-empty high, 2 almost-full low, 3 almost-full high. The write pointer then moves to the next index.
- R3: The write after a write to index 3 lands in index 0, the almost-empty low byte.
- R4: A `wr_clk` edge with `load_n` high or `wen1_n` high leaves the write pointer where it is. A load sequence broken off this way resumes at the next register in order.
- R5: Each assembled offset is `{high[ADDR_W-9:0], low[7:0]}`. A high register keeps only the low `ADDR_W-8` bits of `din`, and its other bits read back as zero.
- R6: On a rising `rd_clk` edge with `load_n`, `ren1_n` and `ren2_n` all low, the register under the read pointer appears on `dout`. The read pointer then advances in the same wrapping order as the write pointer.
- R7: A `rd_clk` edge with `load_n`, `ren1_n` or `ren2_n` high leaves both `dout` and the read pointer unchanged.
- R8: While `load_n` is high, `din` and `wen1_n` have no effect on either offset.
- R9: The read pointer after reset starts at index 0, so the first readback returns the almost-empty low default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock; loads happen on its rising edge |
| rd_clk | input | 1 | Read-side clock; readback happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| load_n | input | 1 | Active-low selection of the offset registers instead of FIFO storage |
| wen1_n | input | 1 | Active-low primary write enable |
| ren1_n | input | 1 | Active-low first read enable |
| ren2_n | input | 1 | Active-low second read enable |
| din | input | 8 | Byte loaded into the current offset register |
| dout | output | 8 | Registered readback byte |
| empty_ofs | output | ADDR_W | Assembled almost-empty offset for the flag logic |
| full_ofs | output | ADDR_W | Assembled almost-full offset for the flag logic |

## Verification
The assertions assume that `rst_n` is held low across at least one edge of each clock before any load or read. They also assume that the register contents do not change while a readback crosses into the read domain. The bench meets both assumptions. It runs the two clocks from one source and asserts reset for several cycles before it starts. This lets a write and a readback fall on the same edge, where the read must return the value from before that edge. Directed sequences cover full loads, wrap-around, broken-off loads and blocked reads. After them comes a long random mix of the control pins.

// File: rtl/ofs_pkg.sv
// Package: shared constants and the register index type for the offset store.
// Assumes exactly four byte registers, visited in a fixed cyclic order.
package ofs_pkg;
    localparam int OFS_NREG  = 4;
    localparam int OFS_BYTE  = 8;
    localparam int OFS_IDX_W = $clog2(OFS_NREG);

    typedef logic [OFS_IDX_W-1:0] ofs_idx_t;

    // Visiting order; the low bit of the index marks a high byte.
    localparam ofs_idx_t IDX_EMPTY_LO = 2'd0;
    localparam ofs_idx_t IDX_EMPTY_HI = 2'd1;
    localparam ofs_idx_t IDX_FULL_LO  = 2'd2;
    localparam ofs_idx_t IDX_FULL_HI  = 2'd3;
endpackage

// File: rtl/ofs_ptr.sv
// Module: wrapping register pointer that advances by one on each enabled
// edge and returns to zero after the last register.
// Assumes: synchronous active-low reset; N >= 2.
module ofs_ptr #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    // Pointer update: reset to the first register, wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (step)
            idx <= (idx == LAST) ? '0 : idx + W'(1);
    end
endmodule

// File: rtl/ofs_regfile.sv
// Module: the four offset byte registers, written in the write-clock domain.
// High-byte registers keep only the bits the FIFO address width needs.
// Assumes: 9 <= ADDR_W <= 16; synchronous active-low reset.
module ofs_regfile
    import ofs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int EMPTY_DEF = 7,
    parameter int FULL_DEF  = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  ofs_idx_t                          widx,
    input  logic [OFS_BYTE-1:0]               wdata,
    output logic [OFS_NREG-1:0][OFS_BYTE-1:0] bytes_q,
    output logic [ADDR_W-1:0]                 empty_ofs,
    output logic [ADDR_W-1:0]                 full_ofs
);
    localparam int HI_W = ADDR_W - OFS_BYTE;
    localparam logic [ADDR_W-1:0] EDEF = ADDR_W'(EMPTY_DEF);
    localparam logic [ADDR_W-1:0] FDEF = ADDR_W'(FULL_DEF);

    for (genvar g = 0; g < OFS_NREG; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] DEF = (g < 2) ? EDEF : FDEF;
        if (g % 2 == 1) begin : g_hi
            logic [HI_W-1:0] q;
            // High byte: store only the address bits above the low byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= DEF[ADDR_W-1:OFS_BYTE];
                else if (we && widx == ofs_idx_t'(g))
                    q <= wdata[HI_W-1:0];
            end
            assign bytes_q[g] = OFS_BYTE'(q);
        end else begin : g_lo
            logic [OFS_BYTE-1:0] q;
            // Low byte: store the whole input byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= DEF[OFS_BYTE-1:0];
                else if (we && widx == ofs_idx_t'(g))
                    q <= wdata;
            end
            assign bytes_q[g] = q;
        end
    end

    assign empty_ofs = {bytes_q[IDX_EMPTY_HI][HI_W-1:0], bytes_q[IDX_EMPTY_LO]};
    assign full_ofs  = {bytes_q[IDX_FULL_HI][HI_W-1:0],  bytes_q[IDX_FULL_LO]};
endmodule

// File: rtl/ofs_readout.sv
// Module: read-domain output register that selects the byte under the read
// pointer when readback is enabled and otherwise holds its value.
// Assumes: register contents are quiet while a readback is in progress.
module ofs_readout
    import ofs_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  ofs_idx_t                          ridx,
    input  logic [OFS_NREG-1:0][OFS_BYTE-1:0] bytes_q,
    output logic [OFS_BYTE-1:0]               dout
);
    // Output register: clear on reset, load the selected byte on readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (rd_en)
            dout <= bytes_q[ridx];
    end
endmodule

// File: rtl/ofs_load_unit.sv
// Module: threshold offset store for a programmable-flag FIFO. It loads and
// reads four byte registers through wrapping pointers, one pointer per clock
// domain, and presents the assembled almost-empty and almost-full offsets.
// Assumes: rst_n is held low across an edge of both clocks; offsets are not
// loaded while a readback is running if the clocks are unrelated.
module ofs_load_unit
    import ofs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int EMPTY_DEF = 7,
    parameter int FULL_DEF  = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic [ADDR_W-1:0] empty_ofs,
    output logic [ADDR_W-1:0] full_ofs
);
    logic                              wr_step;
    logic                              rd_step;
    ofs_idx_t                          wr_idx;
    ofs_idx_t                          rd_idx;
    logic [OFS_NREG-1:0][OFS_BYTE-1:0] bytes_q;

    // Decode of the active-low controls into load and readback strobes.
    assign wr_step = !load_n && !wen1_n;
    assign rd_step = !load_n && !ren1_n && !ren2_n;

    ofs_ptr #(.N(OFS_NREG)) u_wptr (
        .clk(wr_clk), .rst_n(rst_n), .step(wr_step), .idx(wr_idx)
    );

    ofs_ptr #(.N(OFS_NREG)) u_rptr (
        .clk(rd_clk), .rst_n(rst_n), .step(rd_step), .idx(rd_idx)
    );

    ofs_regfile #(
        .ADDR_W(ADDR_W), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)
    ) u_regs (
        .clk(wr_clk), .rst_n(rst_n), .we(wr_step), .widx(wr_idx),
        .wdata(din), .bytes_q(bytes_q),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    ofs_readout u_rdout (
        .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_step), .ridx(rd_idx),
        .bytes_q(bytes_q), .dout(dout)
    );
endmodule

// File: rtl/ofs_load_unit_chk.sv
// Checker: temporal properties of the offset store, bound to ofs_load_unit.
// Assumes the top module's internal pointer nets wr_idx and rd_idx.
module ofs_load_unit_chk
    import ofs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int EMPTY_DEF = 7,
    parameter int FULL_DEF  = 7
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              wen1_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [7:0]        din,
    input logic [7:0]        dout,
    input logic [ADDR_W-1:0] empty_ofs,
    input logic [ADDR_W-1:0] full_ofs,
    input ofs_idx_t          wr_idx,
    input ofs_idx_t          rd_idx
);
    localparam int HI_W = ADDR_W - 8;

    AST_RESET_DEFAULTS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty_ofs == ADDR_W'(EMPTY_DEF) && full_ofs == ADDR_W'(FULL_DEF) && wr_idx == '0)); // R1
    AST_RESET_READSIDE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == 8'd0 && rd_idx == '0)); // R9
    AST_WPTR_ADVANCE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!load_n && !wen1_n) |=> wr_idx == ofs_idx_t'($past(wr_idx) + 2'd1)); // R3
    AST_WPTR_HOLD: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (load_n || wen1_n) |=> $stable(wr_idx)); // R4
    AST_EMPTY_LO_LOAD: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!load_n && !wen1_n && wr_idx == IDX_EMPTY_LO) |=> empty_ofs[7:0] == $past(din)); // R2
    AST_FULL_HI_MASK: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!load_n && !wen1_n && wr_idx == IDX_FULL_HI) |=> full_ofs[ADDR_W-1:8] == $past(din[HI_W-1:0])); // R5
    AST_OFFSETS_FROZEN: assert property (@(posedge wr_clk) disable iff (!rst_n)
        load_n |=> ($stable(empty_ofs) && $stable(full_ofs))); // R8
    AST_RPTR_ADVANCE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && !ren1_n && !ren2_n) |=> rd_idx == ofs_idx_t'($past(rd_idx) + 2'd1)); // R6
    AST_READ_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (load_n || ren1_n || ren2_n) |=> ($stable(dout) && $stable(rd_idx))); // R7
endmodule

bind ofs_load_unit ofs_load_unit_chk #(
    .ADDR_W(ADDR_W), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)
) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
    .wen1_n(wen1_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
    .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .wr_idx(wr_idx), .rd_idx(rd_idx)
);

// File: tb/sim_ofs_load_unit.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks. Both clock ports run from one 250 MHz source.
module sim_ofs_load_unit;
    localparam int ADDR_W  = 12;
    localparam int HI_MASK = (1 << (ADDR_W - 8)) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
    logic [7:0]  din = 8'd0;
    logic [7:0]  dout;
    logic [ADDR_W-1:0] empty_ofs, full_ofs;

    int n_cmp = 0, n_bad = 0;
    int m_reg[4];
    int m_wp = 0, m_rp = 0, m_dout = 0;
    bit checking = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    ofs_load_unit #(.ADDR_W(ADDR_W)) u0 (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .load_n(load_n),
        .wen1_n(wen1_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
        .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    // Reference model: read uses contents from before the edge, then write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg[0] = 7; m_reg[1] = 0; m_reg[2] = 7; m_reg[3] = 0;
            m_wp = 0; m_rp = 0; m_dout = 0;
        end else begin
            if (!load_n && !ren1_n && !ren2_n) begin
                m_dout = m_reg[m_rp];
                m_rp = (m_rp + 1) % 4;
            end
            if (!load_n && !wen1_n) begin
                m_reg[m_wp] = (m_wp % 2 == 1) ? (int'(din) & HI_MASK) : int'(din);
                m_wp = (m_wp + 1) % 4;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, tagged with the current phase.
    always @(negedge clk) begin
        if (checking) begin
            check({phase, " dout"}, int'(dout), m_dout);
            check({phase, " empty"}, int'(empty_ofs), m_reg[1] * 256 + m_reg[0]);
            check({phase, " full"}, int'(full_ofs), m_reg[3] * 256 + m_reg[2]);
        end
    end

    task automatic drv(logic l, logic w, logic r1, logic r2, logic [7:0] d);
        @(negedge clk);
        load_n = l; wen1_n = w; ren1_n = r1; ren2_n = r2; din = d;
    endtask

    task automatic idle();
        drv(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checking = 1'b1;
        rst_n = 1'b1;
        idle();
        // R1: defaults after reset
        check("R1 empty default", int'(empty_ofs), 7);
        check("R1 full default", int'(full_ofs), 7);
        check("R1 dout cleared", int'(dout), 0);

        // R2 R5: full ordered load, high bytes masked
        phase = "R2";
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'h34);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'h78);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'hC3);
        idle();
        check("R2 empty loaded", int'(empty_ofs), 'hA34);
        check("R5 full high masked", int'(full_ofs), 'h378);

        // R3: fifth write wraps to almost-empty low
        phase = "R3";
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'h11);
        idle();
        check("R3 wrap to empty low", int'(empty_ofs), 'hA11);

        // R4 R8: break off, writes with load high are ignored, then resume
        phase = "R4";
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'h06);
        phase = "R8";
        drv(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF);
        drv(1'b1, 1'b0, 1'b1, 1'b1, 8'hEE);
        drv(1'b0, 1'b1, 1'b1, 1'b1, 8'hDD);
        idle();
        check("R8 empty untouched", int'(empty_ofs), 'h611);
        check("R8 full untouched", int'(full_ofs), 'h378);
        phase = "R4";
        drv(1'b0, 1'b0, 1'b1, 1'b1, 8'h99);
        idle();
        check("R4 resume at full low", int'(full_ofs), 'h399);

        // R6: readback in order with wrap; regs are 11,06,99,03
        phase = "R6";
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R6 read idx0", int'(dout), 'h11);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R6 read idx3 masked", int'(dout), 'h03);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R6 read wraps", int'(dout), 'h11);

        // R7: any read enable or load high blocks readback
        phase = "R7";
        drv(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
        drv(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        drv(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R7 dout held", int'(dout), 'h11);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R7 pointer held", int'(dout), 'h06);

        // R9: reset mid-stream, readback restarts at default low byte
        phase = "R9";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R9 first read after reset", int'(dout), 7);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        idle();
        check("R9 second read after reset", int'(dout), 0);

        // R2: random mix of loads and reads, same-edge overlap included
        phase = "R2 R6 mix";
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] c;
            c = 4'($urandom);
            drv(c[0] & c[1], c[2] & c[3], 1'($urandom), c[1] & c[3], 8'($urandom));
        end
        idle();
        idle();
        finish_run();
    end
endmodule